// File: doc/BRIEF.md
# Event-Limited Up/Down Timer Counter

This block is the counting core of a general-purpose timer. The counter does not wrap at a fixed terminal value. Two per-event bitmasks control it instead. One mask picks the events that act as a limit. The other picks the events that stop the counter. A limit clears the count when the counter runs in one direction only. When it runs in both directions, a limit makes it reverse. Reaching all ones while counting up, or zero while counting down, is always a limit. A match-0 flag from outside can also act as a limit when its enable is set.

The counter can run as one 32-bit counter. It can also run as two independent 16-bit halves, each with its own direction mode, prescaler, limit mask, halt mask and auto-limit enable. The event-generation and compare logic sit outside the block and deliver single-cycle strobes. Events are sampled only on the prescaled count ticks. A halted half stays frozen until an unhalt strobe. A clear zeroes the count, sets the direction to up and restarts the prescaler phase, but it does not release a halt.

Top module: `evt_limit_timer`

## Requirements
- R1: After a synchronous reset, both counts are zero, both directions are up (`dir_down_*` = 0), neither half is halted, and all limit and halt masks are zero.
- R2: In split mode with one-direction counting, each half counts up by one per tick. On the tick after reaching 16'hFFFF it returns to zero, even when no limit bit is set.
- R3: An event n whose limit-mask bit is set clears a one-direction counter to zero on a tick. An event whose bit is clear has no effect on the count.
- R4: In two-direction mode, a limit flips `dir_down_*` and holds the count for that tick. Down-counting then decrements per tick. When the count is zero while counting down, the next tick flips the direction back to up and holds zero. A limit event while counting down also reverses the direction.
- R5: With the auto-limit enable of a half set, a `match0_*` pulse on a tick acts as a limit. With the enable clear, the pulse is ignored.
- R6: A half with prescale value P advances once every P+1 clocks. The first advance after a clear comes on the (P+1)-th clock edge.
- R7: A halt-mask event on a tick sets `halted_*` and freezes that half's count. Later events do not change it. When a halt event and a limit event fall on the same tick, the halt wins and the count is held.
- R8: Only an unhalt strobe releases a halted half. A clear while halted zeroes the count, and the half stays halted.
- R9: A clear sets the half's count to zero and its direction to up, and restarts its prescaler phase. The clear takes priority over a tick in the same cycle.
- R10: With `unify` = 1, the low controls and low mask bits drive a single 32-bit counter on `count_o`, which carries from bit 15 into bit 16.
- R11: In split mode, `count_o` = {high, low}. The high half uses mask bits 31:16, so event n sits at bit 16+n. Each mask register's low and high parts are written by their own strobe, or by both strobes together in one 32-bit write.
- R12: An event strobe in a clock cycle that is not a tick of its half has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| unify | input | 1 | 1 = single 32-bit counter, 0 = two 16-bit halves |
| bidir_lo | input | 1 | Low/unified half counts in both directions |
| bidir_hi | input | 1 | High half counts in both directions |
| pre_lo | input | 8 | Low/unified prescale value |
| pre_hi | input | 8 | High prescale value |
| autolim_lo | input | 1 | Low/unified match-0 auto-limit enable |
| autolim_hi | input | 1 | High match-0 auto-limit enable |
| match0_lo | input | 1 | Match-0 hit flag for low/unified counter |
| match0_hi | input | 1 | Match-0 hit flag for high counter |
| clr_lo | input | 1 | Clear low/unified counter |
| clr_hi | input | 1 | Clear high counter |
| unhalt_lo | input | 1 | Release halt of low/unified counter |
| unhalt_hi | input | 1 | Release halt of high counter |
| lim_wr_lo | input | 1 | Write limit mask bits 15:0 |
| lim_wr_hi | input | 1 | Write limit mask bits 31:16 |
| lim_wdata | input | 32 | Limit mask write data |
| halt_wr_lo | input | 1 | Write halt mask bits 15:0 |
| halt_wr_hi | input | 1 | Write halt mask bits 31:16 |
| halt_wdata | input | 32 | Halt mask write data |
| evt | input | 16 | Event-occurred strobes, bit n = event n |
| count_o | output | 32 | Unified count, or {high, low} in split mode |
| dir_down_lo | output | 1 | Low/unified counter is counting down |
| dir_down_hi | output | 1 | High counter is counting down |
| halted_lo | output | 1 | Low/unified counter is halted |
| halted_hi | output | 1 | High counter is halted |

## Verification
The counting function is driven with plain free runs, with selected and unselected event pulses, with events placed on and off prescaled ticks, and with a halt and a limit in the same cycle. Each pattern tells a different fault apart. A pulse of an unselected event shows a mask that decodes the wrong bit. An off-tick pulse shows an event path that skips the prescaler gate. The combined halt and limit pulse shows the wrong priority. Two long runs reach the 16-bit all-ones point. In split mode this shows the implicit wrap. In unified mode it shows the carry into bit 16. The two-direction runs reverse once on an event and once at zero. This shows whether the count holds or steps on a reversal.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int EVT_N  = 16;
  localparam int HALF_W = 16;
  localparam int PRE_W  = 8;

  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam logic [PRE_W-1:0] PH_ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0] ph_q;

  assign tick = run && !clr && (ph_q == pre);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph_q <= '0;
    end else if (run) begin
      ph_q <= (ph_q == pre) ? '0 : ph_q + PH_ONE;
    end
  end

  // R6: with a nonzero divider held steady, two ticks never fall on adjacent clocks
  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && (pre != '0)) |=> (!tick || !$stable(pre)));

  // R9: a clear restarts the phase, so no tick follows unless the divider is zero
  a_r9_clr_phase: assert property (@(posedge clk) disable iff (rst)
    (clr && (pre != '0)) |=> (!tick || !$stable(pre)));
endmodule

// File: rtl/tmr_engine.sv
module tmr_engine
  import tmr_pkg::*;
#(
  parameter int W     = 32,
  parameter int HW    = 16,
  parameter int EVT_N = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wide,
  input  logic             bidir,
  input  logic [PRE_W-1:0] pre,
  input  logic             autolim,
  input  logic             match0,
  input  logic             clr,
  input  logic             unhalt,
  input  logic             lim_we,
  input  logic [EVT_N-1:0] lim_wd,
  input  logic             halt_we,
  input  logic [EVT_N-1:0] halt_wd,
  input  logic [EVT_N-1:0] evt,
  output logic [W-1:0]     cnt,
  output logic             dir_down,
  output logic             halted
);
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [EVT_N-1:0] lim_mask_q, halt_mask_q;
  logic [W-1:0]     cnt_q;
  cnt_dir_e         dir_q;
  logic             halted_q;
  logic             tick, at_top, at_end, evt_lim, halt_hit, limit;

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (en && !halted_q),
    .clr  (clr),
    .pre  (pre),
    .tick (tick)
  );

  always_comb begin
    at_top   = wide ? (&cnt_q) : (&cnt_q[HW-1:0]);
    at_end   = (dir_q == CNT_DOWN) ? (cnt_q == '0) : at_top;
    evt_lim  = (|(evt & lim_mask_q)) || (autolim && match0);
    halt_hit = |(evt & halt_mask_q);
    limit    = evt_lim || at_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_mask_q  <= '0;
      halt_mask_q <= '0;
      cnt_q       <= '0;
      dir_q       <= CNT_UP;
      halted_q    <= 1'b0;
    end else begin
      if (lim_we)  lim_mask_q  <= lim_wd;
      if (halt_we) halt_mask_q <= halt_wd;
      if (clr) begin
        cnt_q <= '0;
        dir_q <= CNT_UP;
      end else if (tick) begin
        if (halt_hit) begin
          halted_q <= 1'b1;
        end else if (limit) begin
          if (bidir) begin
            dir_q <= (dir_q == CNT_UP) ? CNT_DOWN : CNT_UP;
          end else begin
            cnt_q <= '0;
            dir_q <= CNT_UP;
          end
        end else if (dir_q == CNT_DOWN) begin
          cnt_q <= cnt_q - CNT_ONE;
        end else begin
          cnt_q <= cnt_q + CNT_ONE;
        end
      end
      if (unhalt) halted_q <= 1'b0;
    end
  end

  assign cnt      = cnt_q;
  assign dir_down = (dir_q == CNT_DOWN);
  assign halted   = halted_q;

  // R9: clear leaves a zero count counting upward
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0 && !dir_down));

  // R7: a halted half without a clear keeps its count
  a_r7_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    (halted && !clr) |=> $stable(cnt));

  // R7: a halt event on a tick always wins, even against a limit
  a_r7_halt_wins: assert property (@(posedge clk) disable iff (rst)
    (tick && halt_hit && !halted && !unhalt) |=> (halted && $stable(dir_down)));

  // R8: only the unhalt strobe releases the halt, a clear does not
  a_r8_clr_keeps_halt: assert property (@(posedge clk) disable iff (rst)
    (halted && !unhalt) |=> halted);

  // R4: a two-direction reversal holds the count
  a_r4_reverse_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && !unhalt && $changed(dir_down) && !$past(clr) && bidir && $past(bidir))
      |-> $stable(cnt));
endmodule

// File: rtl/evt_limit_timer.sv
module evt_limit_timer
  import tmr_pkg::*;
#(
  parameter int NEVT = EVT_N,
  parameter int HW   = HALF_W,
  parameter int PW   = PRE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            unify,
  input  logic            bidir_lo,
  input  logic            bidir_hi,
  input  logic [PW-1:0]   pre_lo,
  input  logic [PW-1:0]   pre_hi,
  input  logic            autolim_lo,
  input  logic            autolim_hi,
  input  logic            match0_lo,
  input  logic            match0_hi,
  input  logic            clr_lo,
  input  logic            clr_hi,
  input  logic            unhalt_lo,
  input  logic            unhalt_hi,
  input  logic            lim_wr_lo,
  input  logic            lim_wr_hi,
  input  logic [2*HW-1:0] lim_wdata,
  input  logic            halt_wr_lo,
  input  logic            halt_wr_hi,
  input  logic [2*HW-1:0] halt_wdata,
  input  logic [NEVT-1:0] evt,
  output logic [2*HW-1:0] count_o,
  output logic            dir_down_lo,
  output logic            dir_down_hi,
  output logic            halted_lo,
  output logic            halted_hi
);
  localparam int FW = 2 * HW;

  logic [FW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;

  // low engine doubles as the unified 32-bit counter
  tmr_engine #(.W(FW), .HW(HW), .EVT_N(NEVT), .PRE_W(PW)) u_lo (
    .clk      (clk),
    .rst      (rst),
    .en       (1'b1),
    .wide     (unify),
    .bidir    (bidir_lo),
    .pre      (pre_lo),
    .autolim  (autolim_lo),
    .match0   (match0_lo),
    .clr      (clr_lo),
    .unhalt   (unhalt_lo),
    .lim_we   (lim_wr_lo),
    .lim_wd   (lim_wdata[NEVT-1:0]),
    .halt_we  (halt_wr_lo),
    .halt_wd  (halt_wdata[NEVT-1:0]),
    .evt      (evt),
    .cnt      (lo_cnt),
    .dir_down (dir_down_lo),
    .halted   (halted_lo)
  );

  // high engine idles in unified mode
  tmr_engine #(.W(HW), .HW(HW), .EVT_N(NEVT), .PRE_W(PW)) u_hi (
    .clk      (clk),
    .rst      (rst),
    .en       (!unify),
    .wide     (1'b1),
    .bidir    (bidir_hi),
    .pre      (pre_hi),
    .autolim  (autolim_hi),
    .match0   (match0_hi),
    .clr      (clr_hi),
    .unhalt   (unhalt_hi),
    .lim_we   (lim_wr_hi),
    .lim_wd   (lim_wdata[HW +: NEVT]),
    .halt_we  (halt_wr_hi),
    .halt_wd  (halt_wdata[HW +: NEVT]),
    .evt      (evt),
    .cnt      (hi_cnt),
    .dir_down (dir_down_hi),
    .halted   (halted_hi)
  );

  assign count_o = unify ? lo_cnt : {hi_cnt, lo_cnt[HW-1:0]};

  // R2: in split mode the low half never leaves its 16-bit range once cleared
  a_r2_split_range: assert property (@(posedge clk) disable iff (rst)
    (!unify && $past(!unify) && $past(lo_cnt[FW-1:HW] == '0)) |-> (lo_cnt[FW-1:HW] == '0));
endmodule

// File: tb/evt_limit_timer_test.sv
module evt_limit_timer_test;
  localparam int K_ALL = 0, K_LO = 1, K_HI = 2, K_DLO = 3, K_DHI = 4, K_HLO = 5, K_HHI = 6;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        unify = 0, bidir_lo = 0, bidir_hi = 0;
  logic [7:0]  pre_lo = 0, pre_hi = 0;
  logic        autolim_lo = 0, autolim_hi = 0, match0_lo = 0, match0_hi = 0;
  logic        clr_lo = 0, clr_hi = 0, unhalt_lo = 0, unhalt_hi = 0;
  logic        lim_wr_lo = 0, lim_wr_hi = 0, halt_wr_lo = 0, halt_wr_hi = 0;
  logic [31:0] lim_wdata = 0, halt_wdata = 0;
  logic [15:0] evt = 0;
  logic [31:0] count_o;
  logic        dir_down_lo, dir_down_hi, halted_lo, halted_hi;

  int   n_chk = 0, n_fail = 0;
  bit   done  = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  evt_limit_timer uut (
    .clk(clk), .rst(rst), .unify(unify), .bidir_lo(bidir_lo), .bidir_hi(bidir_hi),
    .pre_lo(pre_lo), .pre_hi(pre_hi), .autolim_lo(autolim_lo), .autolim_hi(autolim_hi),
    .match0_lo(match0_lo), .match0_hi(match0_hi), .clr_lo(clr_lo), .clr_hi(clr_hi),
    .unhalt_lo(unhalt_lo), .unhalt_hi(unhalt_hi), .lim_wr_lo(lim_wr_lo),
    .lim_wr_hi(lim_wr_hi), .lim_wdata(lim_wdata), .halt_wr_lo(halt_wr_lo),
    .halt_wr_hi(halt_wr_hi), .halt_wdata(halt_wdata), .evt(evt), .count_o(count_o),
    .dir_down_lo(dir_down_lo), .dir_down_hi(dir_down_hi), .halted_lo(halted_lo),
    .halted_hi(halted_hi)
  );

  function automatic logic [31:0] observe(int kind);
    case (kind)
      K_ALL:   return count_o;
      K_LO:    return {16'h0, count_o[15:0]};
      K_HI:    return {16'h0, count_o[31:16]};
      K_DLO:   return {31'h0, dir_down_lo};
      K_DHI:   return {31'h0, dir_down_hi};
      K_HLO:   return {31'h0, halted_lo};
      default: return {31'h0, halted_hi};
    endcase
  endfunction

  // driver side: expectation for the state after the coming clock edge
  task automatic chk(int kind, logic [31:0] val, string req);
    exp_t e;
    e.kind = kind; e.exp = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic adv();
    @(negedge clk);
  endtask

  task automatic clear_both();
    clr_lo = 1; clr_hi = 1;
    chk(K_ALL, 32'h0, "R9");
    adv();
    clr_lo = 0; clr_hi = 0;
  endtask

  // monitor side: pops and compares just after each rising edge
  always @(posedge clk) begin
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e   = sb.pop_front();
      act = observe(e.kind);
      n_chk++;
      if (act !== e.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.exp);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) adv();
    // R1 reset state
    chk(K_ALL, 0, "R1"); chk(K_DLO, 0, "R1"); chk(K_DHI, 0, "R1");
    chk(K_HLO, 0, "R1"); chk(K_HHI, 0, "R1");
    adv();
    rst = 0;
    clear_both();

    // R2 split free run, both halves
    chk(K_ALL, 32'h0001_0001, "R2"); adv();
    chk(K_ALL, 32'h0002_0002, "R2"); adv();
    chk(K_ALL, 32'h0003_0003, "R2"); adv();

    // R3 / R11 limit masks written together: low bit 3, high bit 16+5
    lim_wr_lo = 1; lim_wr_hi = 1; lim_wdata = 32'h0020_0008;
    adv();
    lim_wr_lo = 0; lim_wr_hi = 0;
    clear_both();
    adv(); adv();
    chk(K_ALL, 32'h0003_0003, "R2"); adv();
    evt = 16'h0020;
    chk(K_LO, 4, "R3 unselected event ignored"); chk(K_HI, 0, "R11 high mask bit 21"); adv();
    evt = 16'h0008;
    chk(K_LO, 0, "R3 selected event clears"); chk(K_HI, 1, "R11"); adv();
    evt = 0;

    // R6 / R12 prescale 2 on low, 0 on high
    pre_lo = 2;
    clear_both();
    chk(K_ALL, 32'h0001_0000, "R6"); adv();
    chk(K_ALL, 32'h0002_0000, "R6"); adv();
    chk(K_ALL, 32'h0003_0001, "R6"); adv();
    adv(); adv();
    chk(K_LO, 2, "R6"); adv();
    evt = 16'h0008;
    chk(K_LO, 2, "R12 off-tick event ignored"); adv();
    evt = 0;
    adv();
    evt = 16'h0008;
    chk(K_LO, 0, "R3 on tick"); adv();
    evt = 0;
    pre_lo = 0;

    // R4 two-direction low half
    bidir_lo = 1;
    clear_both();
    adv(); adv();
    chk(K_LO, 3, "R4"); chk(K_DLO, 0, "R4"); adv();
    evt = 16'h0008;
    chk(K_LO, 3, "R4 hold at reversal"); chk(K_DLO, 1, "R4"); adv();
    evt = 0;
    chk(K_LO, 2, "R4 down"); adv();
    chk(K_LO, 1, "R4 down"); adv();
    chk(K_LO, 0, "R4 down"); chk(K_DLO, 1, "R4"); adv();
    chk(K_LO, 0, "R4 zero reverses"); chk(K_DLO, 0, "R4 zero reverses"); adv();
    chk(K_LO, 1, "R4"); adv();
    chk(K_LO, 2, "R4"); adv();
    evt = 16'h0008;
    chk(K_LO, 2, "R4 event reverses"); chk(K_DLO, 1, "R4"); adv();
    evt = 0;
    chk(K_LO, 1, "R4"); adv();
    clr_lo = 1;
    chk(K_LO, 0, "R9 clear"); chk(K_DLO, 0, "R9 direction up"); adv();
    clr_lo = 0;
    chk(K_LO, 1, "R9 counts up after clear"); adv();
    bidir_lo = 0;

    // R5 auto-limit
    autolim_lo = 1;
    clear_both();
    adv();
    chk(K_LO, 2, "R5"); adv();
    match0_lo = 1;
    chk(K_LO, 0, "R5 match limit"); adv();
    match0_lo = 0; autolim_lo = 0;
    chk(K_LO, 1, "R5"); adv();
    match0_lo = 1;
    chk(K_LO, 2, "R5 disabled ignored"); adv();
    match0_lo = 0;

    // R7 / R8 / R11 halt masks written separately: low bit 7, high bit 16+9
    halt_wr_lo = 1; halt_wdata = 32'h0000_0080; adv();
    halt_wr_lo = 0; halt_wr_hi = 1; halt_wdata = 32'h0200_0000; adv();
    halt_wr_hi = 0;
    clear_both();
    adv();
    chk(K_ALL, 32'h0002_0002, "R7"); adv();
    evt = 16'h0088;
    chk(K_LO, 2, "R7 halt wins"); chk(K_HLO, 1, "R7"); chk(K_HI, 3, "R11"); adv();
    evt = 0;
    chk(K_LO, 2, "R7 frozen"); chk(K_HI, 4, "R7 high unaffected"); adv();
    evt = 16'h0008;
    chk(K_LO, 2, "R7 events ignored"); adv();
    evt = 0;
    chk(K_HLO, 1, "R7"); adv();
    clr_lo = 1;
    chk(K_LO, 0, "R8 clear while halted"); chk(K_HLO, 1, "R8 stays halted"); adv();
    clr_lo = 0;
    chk(K_LO, 0, "R8"); adv();
    unhalt_lo = 1;
    chk(K_HLO, 0, "R8 unhalt"); chk(K_LO, 0, "R8"); adv();
    unhalt_lo = 0;
    chk(K_LO, 1, "R8 resumes"); chk(K_HI, 10, "R11"); adv();
    evt = 16'h0200;
    chk(K_HHI, 1, "R7 high halt"); chk(K_HI, 10, "R7"); chk(K_LO, 2, "R11"); adv();
    evt = 0;
    chk(K_HI, 10, "R7 high frozen"); chk(K_LO, 3, "R7"); adv();
    unhalt_hi = 1; adv();
    unhalt_hi = 0;

    // R2 wrap at 16-bit all ones in split mode
    lim_wr_lo = 1; lim_wr_hi = 1; lim_wdata = 0;
    halt_wr_lo = 1; halt_wr_hi = 1; halt_wdata = 0;
    adv();
    lim_wr_lo = 0; lim_wr_hi = 0; halt_wr_lo = 0; halt_wr_hi = 0;
    clear_both();
    repeat (65534) adv();
    chk(K_ALL, 32'hFFFF_FFFF, "R2"); adv();
    chk(K_ALL, 32'h0000_0000, "R2 wrap"); adv();
    chk(K_ALL, 32'h0001_0001, "R2"); adv();

    // R10 unified 32-bit counter with low mask
    unify = 1;
    lim_wr_lo = 1; lim_wr_hi = 1; lim_wdata = 32'h0008_0008;
    adv();
    lim_wr_lo = 0; lim_wr_hi = 0;
    clear_both();
    repeat (65534) adv();
    chk(K_ALL, 32'h0000_FFFF, "R10"); adv();
    chk(K_ALL, 32'h0001_0000, "R10 carry"); adv();
    chk(K_ALL, 32'h0001_0001, "R10"); adv();
    evt = 16'h0008;
    chk(K_ALL, 32'h0, "R10 low mask limit"); adv();
    evt = 0;
    adv(); adv();

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule